// File: doc/BRIEF.md
# Soft/Hard Switch State Sequencer

This block keeps, for a bank of analog switch controls, the wanted open or closed state and the transition style of each switch, and carries out decoded commands on them. A command arrives as a one-cycle strobe with a 2-bit opcode and a data word holding one bit per switch. Each switch drives a gate-enable line and a ramp level. The ramp level models how far the switch has moved towards fully closed. A switch in soft mode moves one level per clock. A switch in hard mode jumps to its end level in a single clock.

When one command changes several switches, the switches that open must finish opening before any switch of the same mode starts to close. This ordering is kept separately inside the soft group and inside the hard group, and a soft switch and a hard switch never wait for each other. A command that arrives while a transition is under way goes into a one-deep holding slot. While a command waits there, soft ramps take larger steps so that the earlier transition ends sooner.

Top module: `swseq_top`

## Requirements
- R1: After reset every gate enable and every ramp level is 0, busy is low, and every switch is in soft mode.
- R2: Opcode encoding is 2'b00 reset, 2'b01 mode set, 2'b10 no-op and 2'b11 switch set. A no-op leaves every gate enable, ramp level and mode unchanged and does not raise busy.
- R3: A reset command sets every ramp level and gate enable to 0 on the clock that applies it, with busy low afterwards, and puts every switch back in soft mode.
- R4: A switch-set command makes data bit i the final state of switch i: 1 means closed (ramp level RAMP_STEPS), 0 means open (ramp level 0). gateEn[i] is high exactly when the ramp level of switch i is nonzero. Switch i's level sits at rampLvl[i*LW +: LW], with LW = clog2(RAMP_STEPS+1).
- R5: With no command held, a soft-mode switch changes its level by 1 per clock, so a full open or close keeps busy high for RAMP_STEPS clocks.
- R6: A mode-set command puts switch i in hard mode when data bit i is 1 and in soft mode when it is 0, with no change to any gate. A hard-mode switch reaches its end level one clock after it is allowed to move.
- R7: Within one mode group, a closing switch keeps its level at 0 until every opening switch of that group has reached level 0. A soft open followed by a soft close takes 2*RAMP_STEPS busy clocks; a hard open followed by a hard close takes 2.
- R8: A closing switch in one mode group does not wait for opening switches of the other group, so the two can conduct at the same time.
- R9: A command that arrives while busy is high is held and is applied once busy falls. A newer command that arrives while one is already held replaces it, and the replaced command never takes effect.
- R10: While a command is held, soft ramps move FAST_MULT levels per clock and stop at their end levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 2 | Opcode: 00 reset, 01 mode set, 10 no-op, 11 switch set |
| cmdData | input | NUM_SW | One bit per switch |
| busy | output | 1 | High while any switch has not reached its end level |
| gateEn | output | NUM_SW | Switch i conducts (level nonzero) |
| rampLvl | output | NUM_SW*LW | Packed ramp levels, switch i at bits i*LW upward |

## Verification
A wrong target or mode bit shows up at the ports within one or two clocks: a hard switch that does not jump, a soft ramp that steps by the wrong amount, or a gate that turns on while a switch of the same mode is still opening. A wrong level register or a wrong step size changes the number of busy clocks, so the bench counts them exactly and also compares the ramp level between two adjacent clocks during an accelerated finish. A fault in the holding slot shows up as a replaced command that takes effect anyway, or as a wrong final gate vector after the bank settles.

// File: rtl/swseq_pkg.sv
package swseq_pkg;
  typedef enum logic [1:0] {
    OP_RESET  = 2'b00,
    OP_MODE   = 2'b01,
    OP_NOP    = 2'b10,
    OP_SWITCH = 2'b11
  } seqOp_e;

  typedef struct packed {
    logic doReset;
    logic doMode;
    logic doSwitch;
    logic fast;
  } seqStrobe_t;
endpackage

// File: rtl/swseq_ctrl.sv
module swseq_ctrl
  import swseq_pkg::*;
#(
  parameter int NUM_SW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [NUM_SW-1:0] cmdData,
  input  logic              busy,
  output seqStrobe_t        strobe,
  output logic [NUM_SW-1:0] applyData
);
  logic              holdValid;
  logic [1:0]        holdOp;
  logic [NUM_SW-1:0] holdData;
  logic              useHold, useIn, go;
  logic [1:0]        selOp;

  always_comb begin
    useHold   = holdValid && !busy;
    useIn     = cmdValid && !busy && !holdValid;
    go        = useHold || useIn;
    selOp     = useHold ? holdOp : cmdOp;
    applyData = useHold ? holdData : cmdData;
    strobe.doReset  = go && (selOp == OP_RESET);
    strobe.doMode   = go && (selOp == OP_MODE);
    strobe.doSwitch = go && (selOp == OP_SWITCH);
    strobe.fast     = holdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdOp    <= OP_NOP;
      holdData  <= '0;
    end else if (cmdValid && (busy || holdValid)) begin
      holdValid <= 1'b1;
      holdOp    <= cmdOp;
      holdData  <= cmdData;
    end else if (useHold) begin
      holdValid <= 1'b0;
    end
  end

  // R9: a command seen during a transition must land in the holding slot
  p_hold_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> holdValid);

  // R9: a held command is released as soon as the bank is idle
  p_hold_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !busy && !cmdValid) |=> !holdValid);
endmodule

// File: rtl/swseq_path.sv
module swseq_path
  import swseq_pkg::*;
#(
  parameter int NUM_SW     = 11,
  parameter int RAMP_STEPS = 64,
  parameter int FAST_MULT  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [NUM_SW-1:0]        applyData,
  output logic                     busy,
  output logic [NUM_SW-1:0]        gateEn,
  output logic [NUM_SW*$clog2(RAMP_STEPS+1)-1:0] rampLvl
);
  localparam int LW = $clog2(RAMP_STEPS + 1);
  localparam logic [LW-1:0] FULL  = LW'(RAMP_STEPS);
  localparam logic [LW:0]   FULLX = (LW+1)'(RAMP_STEPS);
  localparam logic [LW:0]   FSTEP = (LW+1)'(FAST_MULT);

  logic [NUM_SW-1:0] target, mode, lvlNz, lvlFull;
  logic [LW-1:0]     lvl    [NUM_SW];
  logic [LW-1:0]     lvlNxt [NUM_SW];
  logic [LW:0]       stepVal;
  logic              softOpening, hardOpening;

  always_comb begin
    stepVal     = strobe.fast ? FSTEP : (LW+1)'(1);
    softOpening = |(~mode & ~target & lvlNz);
    hardOpening = |(mode & ~target & lvlNz);
    busy        = |(lvlNz & ~target) | |(~lvlFull & target);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.doReset) begin
      target <= '0;
      mode   <= '0;
    end else begin
      if (strobe.doSwitch) target <= applyData;
      if (strobe.doMode)   mode   <= applyData;
    end
  end

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    logic [LW:0] upSum, dnDiff;
    logic        blocked;

    always_comb begin
      upSum   = {1'b0, lvl[i]} + stepVal;
      dnDiff  = {1'b0, lvl[i]} - stepVal;
      blocked = mode[i] ? hardOpening : softOpening;
      if (strobe.doReset)
        lvlNxt[i] = '0;
      else if (target[i]) begin
        if (blocked)       lvlNxt[i] = lvl[i];
        else if (mode[i])  lvlNxt[i] = FULL;
        else if (upSum >= FULLX) lvlNxt[i] = FULL;
        else               lvlNxt[i] = upSum[LW-1:0];
      end else begin
        if (mode[i])       lvlNxt[i] = '0;
        else if ({1'b0, lvl[i]} <= stepVal) lvlNxt[i] = '0;
        else               lvlNxt[i] = dnDiff[LW-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) lvl[i] <= '0;
      else       lvl[i] <= lvlNxt[i];
    end

    assign lvlNz[i]   = (lvl[i] != '0);
    assign lvlFull[i] = (lvl[i] == FULL);
    assign gateEn[i]  = lvlNz[i];
    assign rampLvl[i*LW +: LW] = lvl[i];

    // R5: an unaccelerated soft ramp moves by exactly one level
    p_soft_step_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(mode[i]) && !$past(strobe.fast) && !$past(strobe.doReset) && (lvl[i] != $past(lvl[i])))
      |-> (({1'b0, lvl[i]} == {1'b0, $past(lvl[i])} + 1'b1) || ({1'b0, lvl[i]} + 1'b1 == {1'b0, $past(lvl[i])})));

    // R10: an accelerated soft ramp never moves by more than the fast step
    p_fast_step_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(mode[i]) && $past(strobe.fast) && !$past(strobe.doReset))
      |-> (((lvl[i] >= $past(lvl[i])) ? ({1'b0, lvl[i]} - {1'b0, $past(lvl[i])})
                                      : ({1'b0, $past(lvl[i])} - {1'b0, lvl[i]})) <= FSTEP));

    // R6: a hard switch only ever lands on an end level
    p_hard_end_r6: assert property (@(posedge clk) disable iff (!rstN)
      ($past(mode[i]) && (lvl[i] != $past(lvl[i]))) |-> (lvl[i] == '0 || lvl[i] == FULL));

    // R7: a soft switch may not rise while a soft switch is still opening
    p_bbm_soft_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(mode[i]) && (lvl[i] > $past(lvl[i]))) |-> !$past(softOpening));

    // R7: the same ordering inside the hard group
    p_bbm_hard_r7: assert property (@(posedge clk) disable iff (!rstN)
      ($past(mode[i]) && (lvl[i] > $past(lvl[i]))) |-> !$past(hardOpening));
  end

  // R3: a reset command clears every level, target and mode at once
  p_reset_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.doReset) |-> (lvlNz == '0 && mode == '0 && target == '0));
endmodule

// File: rtl/swseq_top.sv
module swseq_top
  import swseq_pkg::*;
#(
  parameter int NUM_SW     = 11,
  parameter int RAMP_STEPS = 64,
  parameter int FAST_MULT  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [NUM_SW-1:0] cmdData,
  output logic              busy,
  output logic [NUM_SW-1:0] gateEn,
  output logic [NUM_SW*$clog2(RAMP_STEPS+1)-1:0] rampLvl
);
  seqStrobe_t        strobe;
  logic [NUM_SW-1:0] applyData;

  swseq_ctrl #(.NUM_SW(NUM_SW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .busy(busy), .strobe(strobe), .applyData(applyData)
  );

  swseq_path #(.NUM_SW(NUM_SW), .RAMP_STEPS(RAMP_STEPS), .FAST_MULT(FAST_MULT)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .applyData(applyData),
    .busy(busy), .gateEn(gateEn), .rampLvl(rampLvl)
  );

  // R2: an idle no-op leaves the bank idle and untouched
  p_noop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b10 && !busy && !u_ctrl.holdValid) |=> (!busy && $stable(gateEn)));
endmodule

// File: tb/tb_swseq_top.sv
`timescale 1ns/1ps
module tb_swseq_top;
  localparam int NSW = 11;
  localparam int RS  = 64;
  localparam int FM  = 8;
  localparam int LW  = $clog2(RS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b10;
  logic [NSW-1:0] cmdData = '0;
  logic busy;
  logic [NSW-1:0] gateEn;
  logic [NSW*LW-1:0] rampLvl;

  int checks = 0;
  int errors = 0;
  int stable = 0;
  bit finished = 1'b0;
  logic [NSW-1:0] expQ[$];

  always #4 clk = ~clk;

  swseq_top #(.NUM_SW(NSW), .RAMP_STEPS(RS), .FAST_MULT(FM)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .busy(busy), .gateEn(gateEn), .rampLvl(rampLvl)
  );

  function automatic int lvlOf(int i);
    return int'(rampLvl[i*LW +: LW]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [NSW-1:0] data, bit push, logic [NSW-1:0] exp);
    @(negedge clk);
    cmdOp = op; cmdData = data; cmdValid = 1'b1;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
    if (push) expQ.push_back(exp);
  endtask

  // scoreboard monitor: compare the settled gate vector against the queue
  always @(negedge clk) begin
    if (busy) stable = 0;
    else if (stable < 2) stable++;
    if (expQ.size() > 0 && stable >= 2) begin
      logic [NSW-1:0] e;
      e = expQ.pop_front();
      check(gateEn == e, "R4 settled gates", int'(gateEn), int'(e));
    end
  end

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int n;
    bit bad, seen;
    int c, d;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(gateEn == '0 && busy == 1'b0 && rampLvl == '0, "R1 reset state", int'(gateEn), 0);

    // R2 idle no-op changes nothing
    issue(2'b10, '1, 1'b1, '0);
    @(negedge clk);
    check(!busy && rampLvl == '0, "R2 no-op", int'(busy), 0);
    waitIdle();

    // R5 soft close of switch 0 takes RAMP_STEPS busy clocks
    issue(2'b11, 11'h001, 1'b1, 11'h001);
    n = 0; @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    check(n == RS, "R5 soft ramp length", n, RS);
    check(lvlOf(0) == RS, "R4 full level", lvlOf(0), RS);
    waitIdle();

    // R6 mode set for switches 1..3 leaves gates alone
    issue(2'b01, 11'h00E, 1'b1, 11'h001);
    @(negedge clk);
    check(!busy, "R6 mode set no motion", int'(busy), 0);
    waitIdle();

    // R6 hard close in one clock
    issue(2'b11, 11'h005, 1'b1, 11'h005);
    n = 0; @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    check(n == 1, "R6 hard jump", n, 1);
    waitIdle();

    // R7 hard break-before-make: open 2, close 3
    issue(2'b11, 11'h009, 1'b1, 11'h009);
    n = 0; bad = 0; @(negedge clk);
    while (busy) begin n++; if (gateEn[2] && gateEn[3]) bad = 1; @(negedge clk); end
    check(n == 2, "R7 hard open then close", n, 2);
    check(!bad, "R7 hard overlap", int'(bad), 0);
    waitIdle();

    // R8 soft open of 0 does not hold back hard close of 1
    issue(2'b11, 11'h00A, 1'b1, 11'h00A);
    n = 0; seen = 0; @(negedge clk);
    while (busy) begin n++; if (gateEn[0] && gateEn[1]) seen = 1; @(negedge clk); end
    check(seen, "R8 cross-mode overlap", int'(seen), 1);
    check(n == RS, "R8 soft open length", n, RS);
    waitIdle();

    // R7 soft break-before-make: open 0, close 4
    issue(2'b11, 11'h00B, 1'b1, 11'h00B);
    waitIdle();
    issue(2'b11, 11'h01A, 1'b1, 11'h01A);
    n = 0; bad = 0; @(negedge clk);
    while (busy) begin n++; if (gateEn[0] && gateEn[4]) bad = 1; @(negedge clk); end
    check(n == 2*RS, "R7 soft open then close", n, 2*RS);
    check(!bad, "R7 soft overlap", int'(bad), 0);
    waitIdle();

    // R10 held no-op accelerates the soft ramp
    issue(2'b11, 11'h01B, 1'b1, 11'h01B);
    repeat (3) @(negedge clk);
    issue(2'b10, 11'h000, 1'b1, 11'h01B);
    @(negedge clk); c = lvlOf(0);
    @(negedge clk); d = lvlOf(0);
    check(d == c + FM, "R10 fast step", d - c, FM);
    waitIdle();
    check(lvlOf(0) == RS, "R10 ends at full", lvlOf(0), RS);

    // R9 held command replaced by a newer one
    issue(2'b11, 11'h01A, 1'b0, '0);
    issue(2'b11, 11'h004, 1'b0, '0);
    issue(2'b11, 11'h021, 1'b1, 11'h021);
    seen = 0;
    while (expQ.size() != 0) begin
      @(negedge clk);
      if (gateEn[2]) seen = 1;
    end
    check(!seen, "R9 replaced command skipped", int'(seen), 0);

    // R3 reset command clears at once and restores soft mode
    issue(2'b00, 11'h7FF, 1'b1, '0);
    @(negedge clk);
    check(gateEn == '0 && !busy && rampLvl == '0, "R3 immediate clear", int'(gateEn), 0);
    waitIdle();
    issue(2'b11, 11'h008, 1'b1, 11'h008);
    n = 0; @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    check(n == RS, "R3 mode back to soft", n, RS);
    waitIdle();

    // R4 open everything
    issue(2'b11, 11'h000, 1'b1, 11'h000);
    waitIdle();
    check(rampLvl == '0, "R4 all open", int'(gateEn), 0);
    finish();
  end
endmodule